// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32768 Hz reference enable into a programmable periodic event for a real-time clock. The reference runs in the system clock domain as a one-cycle enable strobe. A 15-bit divider counts those strobes. A four-bit rate code picks which power-of-two period, counted in reference strobes, ends one event. Each event is a one-cycle pulse, and it drives the periodic interrupt flag that sits outside this block.

Software reaches the block through one 8-bit register on a simple write-strobe and read-data port. The low nibble holds the rate code. The next three bits hold a reference-select field, and the divider runs only when that field holds the 32 kHz select value. A write to the register also restarts the divider. A new rate therefore starts one whole new period after the write, with no partial first period.

Top module: `rtc_rate_gen`

## Requirements
- R1: A cycle with `wr_en` high loads `wr_data[3:0]` as the rate code and `wr_data[6:4]` as the reference-select field. From the next cycle `rd_data` returns the rate code in bits 3:0 and the select field in bits 6:4, and bit 7 reads 0.
- R2: While the rate code is 0, `tick` stays low however many reference enables arrive.
- R3: For a rate code n from 1 to 15, with the select field at 3'b010, `tick` fires once every 2^(n-1) reference enables. This is 2^(16-n) Hz at a 32768 Hz reference.
- R4: A `tick` pulse appears only in the system cycle right after a cycle in which `ref_en` was high.
- R5: After reset the rate code is 6 and the select field is 3'b010, so `rd_data` reads 8'h26 and `tick` is low. An event then fires every 32 reference enables (1024 Hz).
- R6: A register write clears the divider, and a `ref_en` in the same cycle as the write is not counted. The first event after the write follows exactly 2^(n-1) later reference enables.
- R7: While the select field holds any value other than 3'b010, the divider is held and `tick` stays low.
- R8: Each event is exactly one system-clock cycle high, even when a reference period spans many system cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_en | input | 1 | One-cycle strobe at the 32768 Hz reference rate |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data: rate code in 3:0, reference select in 6:4 |
| rd_data | output | 8 | Register read-back value |
| tick | output | 1 | One-cycle periodic event pulse |

## Verification
The assertions check on every cycle that a zero code or an inactive select field gives no event, and that every event follows a reference strobe. They also check that a write clears the divider and is read back, and that the counter's low bits are zero whenever an event fires. Only the bench scenarios can show the actual period for each code, the reset rate of 1024 Hz, and the exact restart distance after a write. They show this by counting events over known runs of strobes, at full and sparse strobe spacing.

// File: rtl/rtc_rate_pkg.sv
package rtc_rate_pkg;
  localparam int unsigned RR_CNT_W  = 15;
  localparam int unsigned RR_CODE_W = 4;
  localparam int unsigned RR_SEL_W  = 3;
  localparam int unsigned RR_REG_W  = 8;
  localparam logic [RR_SEL_W-1:0] RR_SEL_32K = 3'b010;

  // bits of the divider that must all be zero at an event for a given code
  function automatic logic [RR_CNT_W-1:0] rr_low_mask(input logic [RR_CODE_W-1:0] code);
    logic [RR_CNT_W-1:0] one;
    one = {{(RR_CNT_W-1){1'b0}}, 1'b1};
    if (code == '0) return '0;
    return (one << (code - 1'b1)) - one;
  endfunction

  // event condition on the post-increment divider value
  function automatic logic rr_wrap(input logic [RR_CNT_W-1:0] cnt_next,
                                   input logic [RR_CODE_W-1:0] code);
    return (code != '0) && ((cnt_next & rr_low_mask(code)) == '0);
  endfunction
endpackage

// File: rtl/rtc_rate_reg.sv
module rtc_rate_reg
  import rtc_rate_pkg::*;
#(
  parameter logic [RR_CODE_W-1:0] RST_CODE = 4'd6,
  parameter logic [RR_SEL_W-1:0]  RST_SEL  = RR_SEL_32K
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [RR_REG_W-1:0]  wr_data,
  output logic [RR_CODE_W-1:0] code_o,
  output logic [RR_SEL_W-1:0]  sel_o,
  output logic                 restart_o,
  output logic [RR_REG_W-1:0]  rd_data
);
  logic [RR_CODE_W-1:0] code_q;
  logic [RR_SEL_W-1:0]  sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= RST_CODE;
      sel_q  <= RST_SEL;
    end else if (wr_en) begin
      code_q <= wr_data[RR_CODE_W-1:0];
      sel_q  <= wr_data[RR_CODE_W +: RR_SEL_W];
    end
  end

  assign code_o    = code_q;
  assign sel_o     = sel_q;
  assign restart_o = wr_en;
  assign rd_data   = {{(RR_REG_W-RR_CODE_W-RR_SEL_W){1'b0}}, sel_q, code_q};

  // R1: written fields come back on the read port one cycle later
  p_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[RR_SEL_W+RR_CODE_W-1:0] == $past(wr_data[RR_SEL_W+RR_CODE_W-1:0])));
  // R1: top bit never set
  p_msb_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[RR_REG_W-1] == 1'b0);
endmodule

// File: rtl/rtc_rate_div.sv
module rtc_rate_div
  import rtc_rate_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref_en,
  input  logic                 clr,
  input  logic                 run,
  input  logic [RR_CODE_W-1:0] code,
  output logic                 evt_o
);
  logic [RR_CNT_W-1:0] cnt_q;
  logic [RR_CNT_W-1:0] cnt_inc;
  logic                advance;
  logic                wrap_now;

  assign advance  = run && ref_en && (code != '0) && !clr;
  assign cnt_inc  = cnt_q + {{(RR_CNT_W-1){1'b0}}, 1'b1};
  assign wrap_now = advance && rr_wrap(cnt_inc, code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      evt_o <= 1'b0;
    end else begin
      evt_o <= wrap_now;
      if (clr)          cnt_q <= '0;
      else if (advance) cnt_q <= cnt_inc;
    end
  end

  // R2: a zero code never produces an event
  p_no_evt_code0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (code == '0) |=> !evt_o);
  // R4: events only follow a reference strobe
  p_evt_after_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> $past(ref_en));
  // R6: a restart clears the divider and suppresses the event
  p_clear_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0) && !evt_o);
  // R3: at an event the selected low bits have just wrapped
  p_evt_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> ((cnt_q & rr_low_mask(code)) == '0));
endmodule

// File: rtl/rtc_rate_gen.sv
module rtc_rate_gen
  import rtc_rate_pkg::*;
#(
  parameter logic [RR_CODE_W-1:0] RST_CODE = 4'd6,
  parameter logic [RR_SEL_W-1:0]  RST_SEL  = RR_SEL_32K
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ref_en,
  input  logic                wr_en,
  input  logic [RR_REG_W-1:0] wr_data,
  output logic [RR_REG_W-1:0] rd_data,
  output logic                tick
);
  logic [RR_CODE_W-1:0] rate_code;
  logic [RR_SEL_W-1:0]  ref_sel;
  logic                 div_restart;
  logic                 div_run;

  rtc_rate_reg #(.RST_CODE(RST_CODE), .RST_SEL(RST_SEL)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .code_o    (rate_code),
    .sel_o     (ref_sel),
    .restart_o (div_restart),
    .rd_data   (rd_data)
  );

  assign div_run = (ref_sel == RR_SEL_32K);

  rtc_rate_div u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .ref_en (ref_en),
    .clr    (div_restart),
    .run    (div_run),
    .code   (rate_code),
    .evt_o  (tick)
  );

  // R7: an inactive reference select keeps the output quiet
  p_no_tick_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_sel != RR_SEL_32K) |=> !tick);
  // R8: with a sparse strobe the pulse lasts one cycle
  p_single_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ref_en) |=> !tick);
endmodule

// File: tb/rtc_rate_gen_bench.sv
module rtc_rate_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       tick;

  int total = 0;
  int bad = 0;
  int ev_cnt = 0;
  int run_len = 0;
  int max_run = 0;
  bit done = 0;

  // behavioural reference state
  int  m_code = 6;
  int  m_sel = 2;
  int  m_phase = 0;
  bit  m_tick = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_rate_gen u_rtc_rate_gen (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .tick(tick)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code = 6; m_sel = 2; m_phase = 0; m_tick = 0;
    end else begin
      m_tick = 0;
      if (wr_en) begin
        m_code = wr_data[3:0]; m_sel = wr_data[6:4]; m_phase = 0;
      end else if (ref_en && m_sel == 2 && m_code != 0) begin
        m_phase = m_phase + 1;
        if (m_phase == (1 << (m_code - 1))) begin
          m_tick = 1; m_phase = 0;
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (tick !== m_tick) begin
        bad++;
        $display("FAIL %s tick=%0b expected=%0b", (m_code == 0) ? "R2" :
                 (m_sel != 2) ? "R7" : "R3", tick, m_tick);
      end
      total++;
      if (rd_data !== {1'b0, 3'(m_sel), 4'(m_code)}) begin
        bad++;
        $display("FAIL R1 rd_data=%h expected=%h", rd_data, {1'b0, 3'(m_sel), 4'(m_code)});
      end
      if (tick === 1'b1) begin
        ev_cnt++; run_len++;
        if (run_len > max_run) max_run = run_len;
      end else run_len = 0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v; ref_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    #1 ev_cnt = 0; max_run = 0;
  endtask

  task automatic run_refs(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      ref_en = 1'b1;
      @(negedge clk);
      ref_en = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
    @(negedge clk);
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R5: reset state
    check("R5 reset readback", int'(rd_data), 'h26);
    check("R5 reset tick", int'(tick), 0);
    rst_n = 1'b1;
    @(negedge clk); #1 ev_cnt = 0;
    run_refs(64, 0);
    check("R5 1024Hz over 64 refs", ev_cnt, 2);

    // R3 / R8: fastest rate, continuous and sparse strobe
    write_reg(8'h21);
    run_refs(10, 0);
    check("R3 code1 continuous", ev_cnt, 10);
    write_reg(8'h21);
    run_refs(5, 3);
    check("R3 code1 sparse", ev_cnt, 5);
    check("R8 pulse width", max_run, 1);
    check("R4 after sparse strobes", int'(tick), 0);

    // R3: mid rate with sparse strobes
    write_reg(8'h23);
    run_refs(40, 1);
    check("R3 code3", ev_cnt, 10);
    check("R8 code3 width", max_run, 1);

    // R2: zero code
    write_reg(8'h20);
    check("R1 readback code0", int'(rd_data), 'h20);
    run_refs(100, 0);
    check("R2 code0 silent", ev_cnt, 0);

    // R7 / R1: inactive select, bit 7 masked
    write_reg(8'hFF);
    check("R1 bit7 zero", int'(rd_data), 'h7F);
    run_refs(200, 0);
    check("R7 select inactive", ev_cnt, 0);

    // R6: restart mid-period, ref coinciding with write not counted
    write_reg(8'h24);
    run_refs(5, 0);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h24; ref_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; ref_en = 1'b0;
    #1 ev_cnt = 0;
    run_refs(7, 0);
    check("R6 none before full period", ev_cnt, 0);
    run_refs(1, 0);
    check("R6 first event after 8 refs", ev_cnt, 1);

    // R3 / R6: slowest code boundary
    write_reg(8'h2F);
    run_refs(16383, 0);
    check("R3 code15 one short", ev_cnt, 0);
    run_refs(1, 0);
    check("R3 code15 period", ev_cnt, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule